// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a single burst request into the column addresses that an SDRAM read or write burst visits. A one-cycle start pulse carries a 9-bit starting column, a 3-bit length code and an order bit, all taken from the memory's mode settings. One clock later the block begins to emit one column per cycle, with a valid flag on every beat and a last flag on the final one.

Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned block whose size is the burst length. The upper column bits never change and the low bits wrap. The order is either sequential, where the low bits count up, or interleaved, where the low bits are the starting offset XOR the beat index. A page-length burst walks up through all 512 columns, wrapping from 511 to 0, until a stop request ends it. Length codes that do not exist, and page length combined with interleaved order, are rejected with a one-cycle error pulse.

A memory controller places this block between its command sequencer and the address pins. The sequencer pulses start when it issues a read or write, and it watches busy to know when the column stream is done.

Top module: `col_burst_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, valid_o, busy_o, last_o and err_o are all 0.
- R2: A start pulse accepted while idle makes valid_o high in the next cycle, and the first column emitted equals start_col_i.
- R3: The length code maps 3'b000 to 1 beat, 3'b001 to 2, 3'b010 to 4, 3'b011 to 8 and 3'b111 to page length. A fixed burst emits exactly that many consecutive valid beats.
- R4: With ilv_i=0 and a fixed length N, column bits above log2(N) hold the start value. The low log2(N) bits step up by one per beat modulo N, wrapping inside the aligned block.
- R5: With ilv_i=1 and a fixed length N, the low log2(N) bits of beat k equal the start offset XOR k, and the upper bits hold the start value.
- R6: A page-length burst (code 3'b111, ilv_i=0) adds one to the column per beat modulo 512 and runs until stop_i is high during a beat. That beat carries last_o and is the final one.
- R7: stop_i has no effect during a fixed-length burst or while idle.
- R8: Codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with ilv_i=1, give a one-cycle err_o pulse in the cycle after start and emit no beats.
- R9: A start pulse while busy_o is high, including during the last beat, is ignored and does not disturb the running burst.
- R10: last_o is high exactly on the final beat of a fixed burst. busy_o is high on every beat and drops in the cycle after the last beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst request pulse |
| start_col_i | input | 9 | Starting column of the burst |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Order select: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Ends a page-length burst on the current beat |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is being emitted |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | A burst is in progress |
| err_o | output | 1 | Rejected request, one-cycle pulse |

## Verification
The bench goes after starts near the top of an aligned block, such as column 7 with length 8. A design that carried into the upper bits would step to column 8 there instead of wrapping to 0. Interleaved starts with odd offsets expose a design that adds instead of XORs, because the second beat comes out wrong. Page bursts that start at 511 or run past 512 beats expose a counter that saturates or stops early. Starts and stops injected during running bursts, including on the last beat, catch a block that restarts, shortens its bursts or gives stop an effect on fixed bursts.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  // Length code values; the code decoder depends on this assignment
  localparam logic [2:0] LEN_1    = 3'b000;
  localparam logic [2:0] LEN_2    = 3'b001;
  localparam logic [2:0] LEN_4    = 3'b010;
  localparam logic [2:0] LEN_8    = 3'b011;
  localparam logic [2:0] LEN_PAGE = 3'b111;
  localparam int unsigned LEN_CODE_W = 3;
endpackage

// File: rtl/col_len_decode.sv
module col_len_decode
  import sdram_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [LEN_CODE_W-1:0] code_i,
  input  logic                  ilv_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  page_o,
  output logic                  ok_o
);
  // The mask holds the column bits that move during the burst
  function automatic logic [COL_W-1:0] f_len_mask(input logic [LEN_CODE_W-1:0] c);
    case (c)
      LEN_1:    f_len_mask = '0;
      LEN_2:    f_len_mask = COL_W'(1);
      LEN_4:    f_len_mask = COL_W'(3);
      LEN_8:    f_len_mask = COL_W'(7);
      LEN_PAGE: f_len_mask = '1;
      default:  f_len_mask = '0;
    endcase
  endfunction

  function automatic logic f_code_legal(input logic [LEN_CODE_W-1:0] c, input logic ilv);
    case (c)
      LEN_1, LEN_2, LEN_4, LEN_8: f_code_legal = 1'b1;
      LEN_PAGE:                   f_code_legal = !ilv;
      default:                    f_code_legal = 1'b0;
    endcase
  endfunction

  assign mask_o = f_len_mask(code_i);
  assign page_o = (code_i == LEN_PAGE);
  assign ok_o   = f_code_legal(code_i, ilv_i);
endmodule

// File: rtl/col_beat_ctrl.sv
module col_beat_ctrl #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ok_i,
  input  logic             page_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             stop_i,
  output logic             accept_o,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_q_o,
  output logic             page_q_o,
  output logic             err_o
);
  logic             active_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic             page_q;
  logic             err_q;

  // Named events brought out for the checks
  logic fixed_end;
  logic page_end;
  logic reject;

  assign accept_o  = start_i && !active_q && ok_i;
  assign reject    = start_i && !active_q && !ok_i;
  assign fixed_end = active_q && !page_q && (beat_q == mask_q);
  assign page_end  = active_q && page_q && stop_i;
  assign last_o    = fixed_end || page_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      mask_q   <= '0;
      page_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= reject;
      if (accept_o) begin
        active_q <= 1'b1;
        beat_q   <= '0;
        mask_q   <= mask_i;
        page_q   <= page_i;
      end else if (active_q) begin
        beat_q <= beat_q + 1'b1;
        if (last_o) active_q <= 1'b0;
      end
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign mask_q_o = mask_q;
  assign page_q_o = page_q;
  assign err_o    = err_q;

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !last_o |=> active_q);
  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && last_o |=> !active_q);
  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && start_i && !last_o |=> $stable(mask_q) && $stable(page_q) && (beat_q == $past(beat_q) + 1'b1));
  // R8
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !active_q);
  // R7
  fixed_stop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !page_q && stop_i && (beat_q != mask_q) |=> active_q);
endmodule

// File: rtl/col_addr_form.sv
module col_addr_form #(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  input  logic [COL_W-1:0] beat_i,
  output logic [COL_W-1:0] col_o
);
  function automatic logic [COL_W-1:0] f_seq_off(input logic [COL_W-1:0] s,
                                                 input logic [COL_W-1:0] m,
                                                 input logic [COL_W-1:0] k);
    f_seq_off = ((s & m) + (k & m)) & m;
  endfunction

  function automatic logic [COL_W-1:0] f_ilv_off(input logic [COL_W-1:0] s,
                                                 input logic [COL_W-1:0] m,
                                                 input logic [COL_W-1:0] k);
    f_ilv_off = (s ^ k) & m;
  endfunction

  logic [COL_W-1:0] off;
  assign off = ilv_i ? f_ilv_off(start_col_i, mask_i, beat_i)
                     : f_seq_off(start_col_i, mask_i, beat_i);

  // Each bit is either held from the start column or taken from the moving offset
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = mask_i[i] ? off[i] : start_col_i[i];
  end
endmodule

// File: rtl/col_burst_gen.sv
module col_burst_gen
  import sdram_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  ilv_i,
  input  logic                  stop_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  last_o,
  output logic                  busy_o,
  output logic                  err_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic             dec_ok;
  logic             accept;
  logic             active;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] mask_q;
  logic             page_q;
  logic [COL_W-1:0] start_q;
  logic             ilv_q;

  col_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i (len_code_i),
    .ilv_i  (ilv_i),
    .mask_o (dec_mask),
    .page_o (dec_page),
    .ok_o   (dec_ok)
  );

  col_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ok_i     (dec_ok),
    .page_i   (dec_page),
    .mask_i   (dec_mask),
    .stop_i   (stop_i),
    .accept_o (accept),
    .active_o (active),
    .last_o   (last_o),
    .beat_o   (beat),
    .mask_q_o (mask_q),
    .page_q_o (page_q),
    .err_o    (err_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      ilv_q   <= 1'b0;
    end else if (accept) begin
      start_q <= start_col_i;
      ilv_q   <= ilv_i;
    end
  end

  col_addr_form #(.COL_W(COL_W)) u_addr (
    .start_col_i (start_q),
    .mask_i      (mask_q),
    .ilv_i       (ilv_q),
    .beat_i      (beat),
    .col_o       (col_o)
  );

  assign valid_o = active;
  assign busy_o  = active;

  // R2
  first_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept) |-> valid_o && (col_o == $past(start_col_i)));
  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && $past(valid_o) && !page_q && !ilv_q |->
      ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)) &&
      ((col_o & mask_q) == (($past(col_o) + 1'b1) & mask_q)));
  // R5
  ilv_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && $past(valid_o) && ilv_q |-> ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)));
  // R6
  page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && $past(valid_o) && page_q |-> col_o == $past(col_o) + 1'b1);
  // R10
  last_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
endmodule

// File: tb/tb_col_burst_gen.sv
`timescale 1ns/1ps
module tb_col_burst_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o, last_o, busy_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  col_burst_gen dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .busy_o(busy_o), .err_o(err_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected column for beat k, from block size and start offset
  function automatic int exp_col(int s, int code, bit ilv, int k);
    int n, base, o;
    if (code == 7) return (s + k) % 512;
    n = 1 << code;
    base = (s / n) * n;
    o = s % n;
    if (ilv) return base + (o ^ k);
    return base + ((o + k) % n);
  endfunction

  task automatic burst(int s, int code, bit ilv, int stop_at, bit poke_start, bit poke_stop);
    int beats;
    beats = (code == 7) ? stop_at + 1 : (1 << code);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 9'(s); len_code_i = 3'(code); ilv_i = ilv; stop_i = 1'b0;
    for (int k = 0; k < beats; k++) begin
      @(negedge clk);
      start_i = poke_start && ($urandom % 3 == 0);
      start_col_i = 9'($urandom);
      len_code_i = 3'($urandom % 4);
      ilv_i = 1'($urandom);
      if (code == 7) stop_i = (k == stop_at);
      else stop_i = poke_stop && 1'($urandom);
      #1;
      check("R2", "valid", int'(valid_o), 1);
      check("R10", "busy", int'(busy_o), 1);
      if (code == 7) check("R6", "page col", int'(col_o), exp_col(s, code, ilv, k));
      else if (ilv) check("R5", "ilv col", int'(col_o), exp_col(s, code, ilv, k));
      else check("R4", "seq col", int'(col_o), exp_col(s, code, ilv, k));
      check((code == 7) ? "R6" : "R10", "last", int'(last_o), int'(k == beats - 1));
    end
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    #1;
    check((poke_start || poke_stop) ? "R9" : "R3", "valid after end", int'(valid_o), 0);
    check("R10", "busy after end", int'(busy_o), 0);
    check("R7", "no err", int'(err_o), 0);
  endtask

  task automatic bad_start(int code, bit ilv);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 9'($urandom); len_code_i = 3'(code); ilv_i = ilv;
    @(negedge clk);
    start_i = 1'b0;
    #1;
    check("R8", "err pulse", int'(err_o), 1);
    check("R8", "no beat", int'(valid_o), 0);
    @(negedge clk);
    #1;
    check("R8", "err clears", int'(err_o), 0);
    check("R8", "still idle", int'(valid_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int code;
    bit ilv;
    void'($urandom(32'h5D2A_01C3));
    repeat (3) @(negedge clk);
    #1;
    check("R1", "valid in reset", int'(valid_o), 0);
    check("R1", "busy in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1", "valid after reset", int'(valid_o), 0);
    check("R1", "err after reset", int'(err_o), 0);
    check("R1", "last after reset", int'(last_o), 0);

    // Directed corner cases
    burst(7, 3, 0, 0, 0, 0);      // R4: 7,0,1..6
    burst(5, 2, 1, 0, 0, 0);      // R5: 5,4,7,6
    burst(300, 0, 0, 0, 0, 0);    // R3: single beat
    burst(3, 1, 1, 0, 0, 0);      // R5: 3,2
    burst(511, 7, 0, 3, 0, 0);    // R6: 511,0,1,2
    burst(10, 7, 0, 0, 0, 0);     // R6: stop on first beat
    burst(100, 7, 0, 520, 0, 0);  // R6: more than a page
    burst(14, 3, 1, 0, 1, 1);     // R9, R7
    bad_start(4, 0);
    bad_start(5, 1);
    bad_start(6, 0);
    bad_start(7, 1);

    // R7: stop while idle
    @(negedge clk);
    stop_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      #1;
      check("R7", "idle stop", int'(valid_o), 0);
    end
    stop_i = 1'b0;

    // Constrained random mix
    for (int n = 0; n < 300; n++) begin
      code = ($urandom % 5 == 4) ? 7 : int'($urandom % 4);
      ilv = (code == 7) ? 1'b0 : 1'($urandom);
      if ($urandom % 10 == 0) bad_start(4 + int'($urandom % 3), 1'($urandom));
      else burst(int'($urandom % 512), code, ilv, int'($urandom % 32), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule